// File: doc/BRIEF.md
# Infrared Frame Receiver with Station Filter

This block turns a serial infrared bit stream into frame bytes. It takes one bit on each clock-enable tick. It finds frame boundaries from the flag pattern and deletes the zeros the transmitter inserted for transparency. It builds bytes with the least significant bit first and checks the 16-bit CRC that ends each frame. Frames whose first byte does not name this station are discarded, so only frames meant for this station reach the consumer.

Accepted bytes leave on a single-beat byte interface. The first byte of a frame is its address byte, followed by the control and data bytes in order. The last released byte of every frame carries an end-of-frame tag. An abort tag marks frames that ended badly. Two pulse outputs, each raised on the end-of-frame beat, report a CRC mismatch and an aborted frame. The station address and the match enable are static configuration inputs. They are sampled when the address byte completes.

Top module: `irx_rx`

## Requirements
- R1: A frame starts after one or more flags (0111_1110 on the line). Flags that follow each other directly, with nothing between them, produce no output beat and no status pulse.
- R2: After five consecutive 1s on the line, a following 0 is discarded and is not part of the frame content.
- R3: Frame bits are grouped into bytes with the first received bit as bit 0. Bytes leave on `out_valid` in arrival order, and the address byte comes first.
- R4: The two bytes before the closing flag are held back and never appear on the output. The byte before them is output with `out_eof` high.
- R5: The CRC uses polynomial 0x1021 and start value 0xFFFF. It is fed the frame bits in line order, and the received CRC follows most significant bit first. When the check fails on an otherwise sound frame, `crc_err` pulses on the end-of-frame beat, and `out_abort` stays low on that beat.
- R6: With matching enabled, a frame whose address byte equals `cfg_addr` is passed on.
- R7: With matching enabled, a frame whose address byte is 0xFF is always passed on.
- R8: With matching disabled, every frame is passed on, whatever its address byte.
- R9: A frame whose address byte does not match is dropped completely. It produces no beat, no `crc_err` and no `abort_evt`.
- R10: If the frame content before the closing flag is not a whole number of bytes, the released end-of-frame beat has `out_abort` high, `abort_evt` pulses, and `crc_err` stays low.
- R11: Seven consecutive 1s inside an accepted frame end it as aborted. The oldest held byte is released with `out_eof` and `out_abort` high, and `abort_evt` pulses. All bits after that are ignored until the next flag.
- R12: A frame that closes with fewer than three whole bytes releases its oldest byte tagged with end of frame and abort, and `abort_evt` pulses.
- R13: During reset, and in the first cycle after it, `out_valid`, `crc_err` and `abort_evt` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Tick: `bit_in` is valid in this cycle |
| bit_in | input | 1 | Received line bit |
| cfg_addr | input | 8 | Station address for the match |
| cfg_match_en | input | 1 | 1 = filter frames by address, 0 = accept all |
| out_valid | output | 1 | Output byte beat |
| out_byte | output | 8 | Received byte |
| out_eof | output | 1 | Beat is the last byte of its frame |
| out_abort | output | 1 | Frame ended aborted (only with `out_eof`) |
| crc_err | output | 1 | CRC mismatch pulse on the end-of-frame beat |
| abort_evt | output | 1 | Abort pulse on the end-of-frame beat |

## Verification
The closing of a frame has to release the end-of-frame byte and decide the CRC verdict in the same cycle. That cycle falls right after a flag or an abort run, so the status pulse has to line up exactly with the tagged beat. The bench provokes this with frames that have one CRC bit flipped, frames given one to seven extra bits, runs of ones in mid-frame, and frames shorter than three bytes, all mixed into random traffic. For each closing beat it compares the tag bits, the byte and the pulse counts with a model built from the bits it sent. The checker also requires that every pulse lands on a tagged end-of-frame beat.

// File: rtl/irx_pkg.sv
package irx_pkg;

  typedef enum logic [1:0] {
    FS_HUNT = 2'd0,
    FS_RECV = 2'd1,
    FS_SKIP = 2'd2
  } frame_st_t;

endpackage

// File: rtl/irx_destuff.sv
// Line-level run tracker: flags, inserted-zero removal, abort runs.
module irx_destuff #(
  parameter int STUFF_RUN = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic bit_in,
  output logic d_valid,
  output logic d_bit,
  output logic d_flag,
  output logic d_abort
);
  localparam int FLAG_RUN  = STUFF_RUN + 1;
  localparam int ABORT_RUN = STUFF_RUN + 2;
  localparam int CW        = $clog2(ABORT_RUN + 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= '0;
      d_valid <= 1'b0;
      d_bit   <= 1'b0;
      d_flag  <= 1'b0;
      d_abort <= 1'b0;
    end else begin
      d_valid <= 1'b0;
      d_flag  <= 1'b0;
      d_abort <= 1'b0;
      if (bit_en) begin
        if (bit_in) begin
          if (run_q == CW'(FLAG_RUN)) begin
            run_q   <= CW'(ABORT_RUN);
            d_abort <= 1'b1;
          end else if (run_q != CW'(ABORT_RUN)) begin
            run_q   <= run_q + 1'b1;
            d_valid <= 1'b1;
            d_bit   <= 1'b1;
          end
        end else begin
          run_q <= '0;
          if (run_q == CW'(FLAG_RUN)) begin
            d_flag <= 1'b1;
          end else if (run_q != CW'(STUFF_RUN) && run_q != CW'(ABORT_RUN)) begin
            d_valid <= 1'b1;
            d_bit   <= 1'b0;
          end
        end
      end
    end
  end

endmodule

// File: rtl/irx_crc_step.sv
// One serial CRC step, non-reflected, fed with the line bit.
module irx_crc_step #(
  parameter int          CRC_W    = 16,
  parameter logic [15:0] CRC_POLY = 16'h1021
) (
  input  logic [CRC_W-1:0] crc_i,
  input  logic             bit_i,
  output logic [CRC_W-1:0] crc_o
);
  logic fb;
  always_comb begin
    fb    = crc_i[CRC_W-1] ^ bit_i;
    crc_o = {crc_i[CRC_W-2:0], 1'b0};
    if (fb) crc_o = crc_o ^ CRC_POLY[CRC_W-1:0];
  end
endmodule

// File: rtl/irx_holdback.sv
// Delay line that keeps the trailing CRC bytes away from the output.
module irx_holdback #(
  parameter int W     = 8,
  parameter int DEPTH = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_byte,
  input  logic         close,
  input  logic         close_abort,
  output logic         full,
  output logic         empty,
  output logic         out_valid,
  output logic [W-1:0] out_byte,
  output logic         out_eof,
  output logic         out_abort
);
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [W-1:0]    slot_q [DEPTH];
  logic [CNTW-1:0] cnt_q;
  logic [W-1:0]    oldest;

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_slot
      if (gi == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (rst)       slot_q[gi] <= '0;
          else if (push) slot_q[gi] <= push_byte;
        end
      end else begin : g_tail
        always_ff @(posedge clk) begin
          if (rst)       slot_q[gi] <= '0;
          else if (push) slot_q[gi] <= slot_q[gi-1];
        end
      end
    end
  endgenerate

  always_comb begin
    oldest = slot_q[0];
    for (int i = 0; i < DEPTH; i++) begin
      if (cnt_q == CNTW'(i + 1)) oldest = slot_q[i];
    end
  end

  assign full  = (cnt_q == CNTW'(DEPTH));
  assign empty = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      out_valid <= 1'b0;
      out_byte  <= '0;
      out_eof   <= 1'b0;
      out_abort <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_eof   <= 1'b0;
      out_abort <= 1'b0;
      if (push) begin
        if (full) begin
          out_valid <= 1'b1;
          out_byte  <= slot_q[DEPTH-1];
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (close && !empty) begin
        out_valid <= 1'b1;
        out_byte  <= oldest;
        out_eof   <= 1'b1;
        out_abort <= close_abort;
        cnt_q     <= '0;
      end
    end
  end

endmodule

// File: rtl/irx_frame.sv
// Frame sequencer: byte assembly, address decision, CRC residue, closing.
module irx_frame
  import irx_pkg::*;
#(
  parameter int          BYTE_W    = 8,
  parameter int          CRC_W     = 16,
  parameter logic [15:0] CRC_POLY  = 16'h1021,
  parameter logic [15:0] CRC_INIT  = 16'hFFFF,
  parameter int          STUFF_RUN = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              d_valid,
  input  logic              d_bit,
  input  logic              d_flag,
  input  logic              d_abort,
  input  logic [BYTE_W-1:0] cfg_addr,
  input  logic              cfg_match_en,
  input  logic              hb_full,
  input  logic              hb_empty,
  output logic              push,
  output logic [BYTE_W-1:0] push_byte,
  output logic              close,
  output logic              close_abort,
  output logic              crc_err,
  output logic              abort_evt
);
  localparam int BCW = $clog2(BYTE_W);
  // Bits of the closing flag seen as content before it is recognised.
  localparam int FLAG_LEAD = (STUFF_RUN + 2) % BYTE_W;
  localparam logic [BYTE_W-1:0] BCAST = '1;

  frame_st_t         state_q;
  logic [BYTE_W-1:0] sr_q, sr_n;
  logic [BCW-1:0]    bcnt_q;
  logic [CRC_W-1:0]  crc_q, crc_n, snap_q;
  logic              first_q;
  logic              byte_done, addr_ok, aligned, good_close;

  irx_crc_step #(.CRC_W(CRC_W), .CRC_POLY(CRC_POLY)) u_crc (
    .crc_i (crc_q),
    .bit_i (d_bit),
    .crc_o (crc_n)
  );

  always_comb begin
    sr_n        = {d_bit, sr_q[BYTE_W-1:1]};
    byte_done   = d_valid && (state_q == FS_RECV) && (bcnt_q == BCW'(BYTE_W - 1));
    addr_ok     = !cfg_match_en || (sr_n == cfg_addr) || (sr_n == BCAST);
    push        = byte_done && (!first_q || addr_ok);
    push_byte   = sr_n;
    aligned     = (bcnt_q == BCW'(FLAG_LEAD));
    close       = (d_flag || d_abort) && (state_q == FS_RECV) && !hb_empty;
    good_close  = d_flag && aligned && hb_full;
    close_abort = !good_close;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= FS_HUNT;
      sr_q      <= '0;
      bcnt_q    <= '0;
      crc_q     <= CRC_INIT[CRC_W-1:0];
      snap_q    <= CRC_INIT[CRC_W-1:0];
      first_q   <= 1'b1;
      crc_err   <= 1'b0;
      abort_evt <= 1'b0;
    end else begin
      crc_err   <= close && good_close && (snap_q != '0);
      abort_evt <= close && !good_close;
      if (d_flag) begin
        state_q <= FS_RECV;
        sr_q    <= '0;
        bcnt_q  <= '0;
        crc_q   <= CRC_INIT[CRC_W-1:0];
        snap_q  <= CRC_INIT[CRC_W-1:0];
        first_q <= 1'b1;
      end else if (d_abort) begin
        state_q <= FS_HUNT;
      end else if (d_valid && state_q == FS_RECV) begin
        sr_q   <= sr_n;
        bcnt_q <= bcnt_q + 1'b1;
        crc_q  <= crc_n;
        if (byte_done) begin
          snap_q <= crc_n;
          if (first_q) begin
            first_q <= 1'b0;
            if (!addr_ok) state_q <= FS_SKIP;
          end
        end
      end
    end
  end

endmodule

// File: rtl/irx_rx.sv
module irx_rx #(
  parameter int          BYTE_W    = 8,
  parameter int          CRC_W     = 16,
  parameter logic [15:0] CRC_POLY  = 16'h1021,
  parameter logic [15:0] CRC_INIT  = 16'hFFFF,
  parameter int          STUFF_RUN = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              bit_in,
  input  logic [BYTE_W-1:0] cfg_addr,
  input  logic              cfg_match_en,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte,
  output logic              out_eof,
  output logic              out_abort,
  output logic              crc_err,
  output logic              abort_evt
);
  localparam int HOLD_DEPTH = CRC_W / BYTE_W + 1;

  logic              d_valid, d_bit, d_flag, d_abort;
  logic              hb_full, hb_empty;
  logic              push, close, close_abort;
  logic [BYTE_W-1:0] push_byte;

  irx_destuff #(.STUFF_RUN(STUFF_RUN)) u_destuff (
    .clk     (clk),
    .rst     (rst),
    .bit_en  (bit_en),
    .bit_in  (bit_in),
    .d_valid (d_valid),
    .d_bit   (d_bit),
    .d_flag  (d_flag),
    .d_abort (d_abort)
  );

  irx_frame #(
    .BYTE_W    (BYTE_W),
    .CRC_W     (CRC_W),
    .CRC_POLY  (CRC_POLY),
    .CRC_INIT  (CRC_INIT),
    .STUFF_RUN (STUFF_RUN)
  ) u_frame (
    .clk          (clk),
    .rst          (rst),
    .d_valid      (d_valid),
    .d_bit        (d_bit),
    .d_flag       (d_flag),
    .d_abort      (d_abort),
    .cfg_addr     (cfg_addr),
    .cfg_match_en (cfg_match_en),
    .hb_full      (hb_full),
    .hb_empty     (hb_empty),
    .push         (push),
    .push_byte    (push_byte),
    .close        (close),
    .close_abort  (close_abort),
    .crc_err      (crc_err),
    .abort_evt    (abort_evt)
  );

  irx_holdback #(.W(BYTE_W), .DEPTH(HOLD_DEPTH)) u_hold (
    .clk         (clk),
    .rst         (rst),
    .push        (push),
    .push_byte   (push_byte),
    .close       (close),
    .close_abort (close_abort),
    .full        (hb_full),
    .empty       (hb_empty),
    .out_valid   (out_valid),
    .out_byte    (out_byte),
    .out_eof     (out_eof),
    .out_abort   (out_abort)
  );

endmodule

// File: rtl/irx_rx_chk.sv
module irx_rx_chk (
  input logic clk,
  input logic rst,
  input logic out_valid,
  input logic out_eof,
  input logic out_abort,
  input logic crc_err,
  input logic abort_evt,
  input logic d_valid,
  input logic d_flag,
  input logic d_abort
);
  AST_EOF_NEEDS_BEAT: assert property (@(posedge clk) disable iff (rst) out_eof |-> out_valid); // R4
  AST_CRCERR_ON_CLEAN_EOF: assert property (@(posedge clk) disable iff (rst) crc_err |-> (out_valid && out_eof && !out_abort)); // R5
  AST_ABORT_PULSE_TAGGED: assert property (@(posedge clk) disable iff (rst) abort_evt |-> (out_valid && out_eof && out_abort)); // R10
  AST_ABORT_TAG_PULSED: assert property (@(posedge clk) disable iff (rst) (out_valid && out_abort) |-> abort_evt); // R11
  AST_BEAT_SPACING: assert property (@(posedge clk) disable iff (rst) out_valid |=> !out_valid); // R3
  AST_LINE_EVENT_EXCL: assert property (@(posedge clk) disable iff (rst) $onehot0({d_valid, d_flag, d_abort})); // R2
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> (!out_valid && !crc_err && !abort_evt)); // R13
endmodule

bind irx_rx irx_rx_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .out_valid (out_valid),
  .out_eof   (out_eof),
  .out_abort (out_abort),
  .crc_err   (crc_err),
  .abort_evt (abort_evt),
  .d_valid   (d_valid),
  .d_flag    (d_flag),
  .d_abort   (d_abort)
);

// File: tb/irx_rx_tb_top.sv
module irx_rx_tb_top;
  typedef bit bq_t[$];
  typedef logic [7:0] byq_t[$];

  localparam int K_GOOD = 0, K_BADCRC = 1, K_MISAL = 2, K_ONES = 3, K_SHORT = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0, bit_in = 1'b0;
  logic [7:0] cfg_addr = 8'h00;
  logic cfg_match_en = 1'b0;
  logic out_valid, out_eof, out_abort, crc_err, abort_evt;
  logic [7:0] out_byte;

  int total = 0, bad = 0;
  logic [7:0] mb[$];
  bit me[$], ma[$];
  int n_crc = 0, n_abt = 0;

  always #5 clk = ~clk;

  irx_rx dut_i (
    .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
    .cfg_addr(cfg_addr), .cfg_match_en(cfg_match_en),
    .out_valid(out_valid), .out_byte(out_byte), .out_eof(out_eof),
    .out_abort(out_abort), .crc_err(crc_err), .abort_evt(abort_evt)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        mb.push_back(out_byte); me.push_back(out_eof); ma.push_back(out_abort);
      end
      if (crc_err) n_crc++;
      if (abort_evt) n_abt++;
    end
  end

  task automatic chk(string req, bit ok, string act, string exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk("watchdog", 1'b0, "hung", "finished");
    summary();
  end

  function automatic bq_t stuff(bq_t in);
    bq_t o;
    int run = 0;
    foreach (in[i]) begin
      o.push_back(in[i]);
      if (in[i]) begin
        run++;
        if (run == 5) begin o.push_back(1'b0); run = 0; end
      end else run = 0;
    end
    return o;
  endfunction

  function automatic logic [15:0] crc16(bq_t in);
    logic [15:0] c = 16'hFFFF;
    foreach (in[i]) begin
      bit fb = c[15] ^ in[i];
      c = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  task automatic tick(bit b);
    @(negedge clk);
    bit_in = b; bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
    repeat ($urandom % 3) @(negedge clk);
  endtask

  task automatic send_flag();
    tick(0); repeat (6) tick(1); tick(0);
  endtask

  task automatic clear_mon();
    mb.delete(); me.delete(); ma.delete(); n_crc = 0; n_abt = 0;
  endtask

  task automatic run_frame(string req, byq_t fb, int kind);
    bq_t p, raw, d, junk;
    logic [15:0] c;
    byq_t bs;
    logic [7:0] eb[$];
    bit ee[$], ea[$];
    int n, k, r;
    bit matched, ab, ok;
    string act, exp;
    foreach (fb[i]) for (int j = 0; j < 8; j++) p.push_back(fb[i][j]);
    if (kind != K_SHORT) begin
      c = crc16(p);
      if (kind == K_BADCRC) c = c ^ (16'h1 << ($urandom % 16));
      for (int j = 15; j >= 0; j--) p.push_back(c[j]);
    end
    if (kind == K_MISAL) begin
      r = 1 + $urandom % 7;
      for (int j = 0; j < r; j++) p.push_back(bit'($urandom % 2));
    end
    if (kind == K_ONES) p.push_back(1'b0);
    raw = stuff(p);
    clear_mon();
    repeat (1 + $urandom % 2) send_flag();
    foreach (raw[i]) tick(raw[i]);
    d = p;
    if (kind == K_ONES) begin
      repeat (7 + $urandom % 3) tick(1);
      repeat (6) d.push_back(1'b1);
      for (int j = 0; j < 14; j++) junk.push_back(bit'($urandom % 2));
      junk = stuff(junk);
      foreach (junk[i]) tick(junk[i]);
    end else begin
      send_flag();
      d.push_back(1'b0);
      repeat (6) d.push_back(1'b1);
    end
    repeat (6) @(negedge clk);
    n = d.size() / 8;
    for (int i = 0; i < n; i++) begin
      logic [7:0] v;
      for (int j = 0; j < 8; j++) v[j] = d[8*i+j];
      bs.push_back(v);
    end
    matched = (n >= 1) && (!cfg_match_en || bs[0] == cfg_addr || bs[0] == 8'hFF);
    ab = (kind == K_ONES) || (p.size() % 8 != 0) || (n < 3);
    if (matched) begin
      k = (n > 3) ? n - 3 : 0;
      for (int i = 0; i < k; i++) begin eb.push_back(bs[i]); ee.push_back(0); ea.push_back(0); end
      eb.push_back(bs[k]); ee.push_back(1); ea.push_back(ab);
    end
    ok = (mb.size() == eb.size());
    if (ok) foreach (eb[i]) if (mb[i] !== eb[i] || me[i] != ee[i] || ma[i] != ea[i]) ok = 0;
    act = $sformatf("beats=%0d last=%h/%0d/%0d", mb.size(), mb.size() ? mb[mb.size()-1] : 8'h0,
                    me.size() ? me[me.size()-1] : 1'b0, ma.size() ? ma[ma.size()-1] : 1'b0);
    exp = $sformatf("beats=%0d last=%h/%0d/%0d", eb.size(), eb.size() ? eb[eb.size()-1] : 8'h0,
                    ee.size() ? ee[ee.size()-1] : 1'b0, ea.size() ? ea[ea.size()-1] : 1'b0);
    chk({req, " stream"}, ok, act, exp);
    chk({req, " pulses"},
        n_crc == ((matched && !ab && kind == K_BADCRC) ? 1 : 0) && n_abt == ((matched && ab) ? 1 : 0),
        $sformatf("crc=%0d abt=%0d", n_crc, n_abt),
        $sformatf("crc=%0d abt=%0d", (matched && !ab && kind == K_BADCRC) ? 1 : 0, (matched && ab) ? 1 : 0));
  endtask

  function automatic byq_t rand_frame(logic [7:0] addr, int nd);
    byq_t f;
    f.push_back(addr);
    for (int i = 0; i < nd; i++) f.push_back(8'($urandom));
    return f;
  endfunction

  initial begin
    byq_t f;
    void'($urandom(32'h5EED_01));
    repeat (3) @(negedge clk);
    // R13: outputs quiet during reset and the cycle after
    chk("R13 in reset", !out_valid && !crc_err && !abort_evt, $sformatf("%0d%0d%0d", out_valid, crc_err, abort_evt), "000");
    rst = 1'b0;
    @(negedge clk);
    chk("R13 after reset", !out_valid && !crc_err && !abort_evt, $sformatf("%0d%0d%0d", out_valid, crc_err, abort_evt), "000");

    // R1: idle ones then back-to-back flags give nothing
    clear_mon();
    repeat (9) tick(1);
    repeat (3) send_flag();
    repeat (6) @(negedge clk);
    chk("R1 empty flags", mb.size() == 0 && n_crc == 0 && n_abt == 0, $sformatf("beats=%0d", mb.size()), "beats=0");

    cfg_addr = 8'h5A; cfg_match_en = 1'b1;
    // R2 R3 R6: own address, data full of long runs of ones
    f = {8'h5A, 8'h7E, 8'hFF, 8'hF8, 8'h3F, 8'h00};
    run_frame("R2 R3 R6", f, K_GOOD);
    run_frame("R4 address only", rand_frame(8'h5A, 0), K_GOOD);
    run_frame("R7 broadcast", rand_frame(8'hFF, 3), K_GOOD);
    run_frame("R9 mismatch", rand_frame(8'h12, 4), K_GOOD);
    run_frame("R9 mismatch badcrc", rand_frame(8'h13, 2), K_BADCRC);
    cfg_match_en = 1'b0;
    run_frame("R8 filter off", rand_frame(8'h21, 3), K_GOOD);
    cfg_match_en = 1'b1;
    run_frame("R5 crc error", rand_frame(8'h5A, 4), K_BADCRC);
    run_frame("R10 misaligned", rand_frame(8'h5A, 3), K_MISAL);
    run_frame("R11 ones abort", rand_frame(8'h5A, 5), K_ONES);
    run_frame("R11 recover", rand_frame(8'h5A, 2), K_GOOD);
    run_frame("R12 short one", rand_frame(8'h5A, 0), K_SHORT);
    run_frame("R12 short two", rand_frame(8'hFF, 1), K_SHORT);

    for (int t = 0; t < 40; t++) begin
      int kind = $urandom % 5;
      int sel = $urandom % 4;
      logic [7:0] a;
      cfg_match_en = ($urandom % 4) != 0;
      a = (sel == 0) ? 8'hFF : (sel == 1) ? 8'($urandom) : cfg_addr;
      case (kind)
        K_GOOD:   run_frame("R3 R4 R6 random", rand_frame(a, $urandom % 6), K_GOOD);
        K_BADCRC: run_frame("R5 random", rand_frame(a, $urandom % 6), K_BADCRC);
        K_MISAL:  run_frame("R10 random", rand_frame(a, $urandom % 6), K_MISAL);
        K_ONES:   run_frame("R11 random", rand_frame(a, $urandom % 6), K_ONES);
        default:  run_frame("R12 random", rand_frame(a, $urandom % 2), K_SHORT);
      endcase
    end
    summary();
  end
endmodule